// File: doc/BRIEF.md
# Descriptor-Chaining DMA Channel

This block is one memory-to-memory copy channel. It has two ways to get its work. In register mode, software loads a source address, a destination address and a byte count, then launches the copy. In chained mode, software loads only the address of the first descriptor. The channel then reads descriptors from memory and follows the links between them. It copies the region each descriptor names, and it stops after the descriptor whose link word carries the terminator flag.

Data moves one word at a time. Each word is a read at the source followed by a write at the destination, both on a single word-wide master port with request, grant and error signals. A word-wide register slave port gives access to the mode, status and working registers. A level interrupt reports completion, when enabled, and reports any bus error unconditionally. The status flags are write-one-to-clear, so writing back the value just read clears the interrupt.

Top module: `dma_chain_channel`

Register indices on `reg_addr_i`:
- 0: mode. Bit 0 is the launch bit, bit 1 selects register mode (1) or chained mode (0), and bit 2 enables the completion interrupt.
- 1: status. Bit 0 is busy (read-only), bit 1 is error and bit 2 is done.
- 2: source.
- 3: destination.
- 4: byte count.
- 5: current descriptor address.

A descriptor is four words at increasing addresses: +0 source, +4 destination, +8 link, +12 byte count. Bit 0 of the link word marks the last descriptor. The low two bits of the link word are dropped when the next address is formed.

## Requirements
- R1: After reset, status reads 0, `irq_o` is low and `mem_req_o` is low.
- R2: A copy is launched only by a write that changes mode bit 0 from 0 to 1 while the channel is idle. Writing 1 over an existing 1 starts nothing and produces no memory request.
- R3: In register mode (mode bit 1 = 1), the channel copies ceil(count/4) words. Each word is a read at source followed by a write of the same data at destination. Both addresses advance by 4 per word, and the count register ends at 0. A word beyond the rounded-up count is not written.
- R4: Status bit 0 (busy) reads 1 from the cycle after launch until the copy ends, and is 0 when idle.
- R5: In chained mode (mode bit 1 = 0), the channel reads the four descriptor words starting at the current descriptor address and copies that region. It then loads the current descriptor address from the link word with the low bits masked and repeats. It stops after the descriptor whose link bit 0 is 1. At that point the current descriptor register holds that last descriptor's address. A descriptor with count 0 moves no data.
- R6: When a copy or chain finishes, status bit 2 (done) is set and busy falls. `irq_o` then rises if mode bit 2 is 1 and stays low otherwise.
- R7: A granted access with `mem_err_i` high stops the channel at once and sets status bit 1 (error). It clears busy, leaves the source and destination registers at the failing position, and raises `irq_o` regardless of mode bit 2.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit. Writing back the value read from status clears `irq_o`.
- R9: While `mem_req_o` is high without grant, the request, address and direction are held unchanged.
- R10: A register-mode copy with count 0 completes with done set and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_gnt_i | input | 1 | Access accepted this cycle; read data and error are valid with it |
| mem_rdata_i | input | 32 | Memory read data |
| mem_err_i | input | 1 | Access error, valid with grant |
| irq_o | output | 1 | Interrupt, level |

## Verification
The assertions check on every cycle that a stalled request holds its address and direction, and that a launch is followed by busy. They also check that an errored access halts the channel with its addresses frozen and the interrupt raised, that a finish leaves the channel idle, and that each completed write lowers the remaining count. Only the bench scenarios can show the actual copy results. These include the exact order and data of every write in both modes, the rounding of odd counts, the walk through linked descriptors and the terminator, the empty descriptor, and the zero-count copy. The scenarios also cover the ignored repeated launch bit, the gating by the interrupt enable, and the write-back clearing of status.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE} dma_state_e;

  localparam int unsigned REG_AW     = 3;
  localparam int unsigned DESC_WORDS = 4;

  localparam logic [REG_AW-1:0] REG_MODE = 3'd0;
  localparam logic [REG_AW-1:0] REG_STAT = 3'd1;
  localparam logic [REG_AW-1:0] REG_SRC  = 3'd2;
  localparam logic [REG_AW-1:0] REG_DST  = 3'd3;
  localparam logic [REG_AW-1:0] REG_CNT  = 3'd4;
  localparam logic [REG_AW-1:0] REG_CDAR = 3'd5;

  localparam int unsigned MODE_GO     = 0;
  localparam int unsigned MODE_DIRECT = 1;
  localparam int unsigned MODE_EOT_IE = 2;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_ERR  = 1;
  localparam int unsigned STAT_DONE = 2;
endpackage

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              direct_i,
  input  logic              sw_we_i,
  input  logic [REG_AW-1:0] sw_sel_i,
  input  logic [DW-1:0]     sw_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DW-1:0]     src_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     cnt_o,
  output logic [DW-1:0]     cdar_o
);
  localparam int unsigned BYTES = DW / 8;
  localparam int unsigned OFFW  = $clog2(BYTES);
  localparam int unsigned IDXW  = $clog2(DESC_WORDS);
  localparam logic [DW-1:0] STEP  = DW'(BYTES);
  localparam logic [DW-1:0] ALIGN = DW'(BYTES - 1);

  dma_state_e      state_q;
  logic [DW-1:0]   src_q, dst_q, cnt_q, cdar_q, next_q, buf_q;
  logic [IDXW-1:0] fidx_q;
  logic            last_q, direct_q;
  logic            seg_end;

  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_wdata_o = buf_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign seg_end     = (state_q == ST_CHECK) && (cnt_q == '0);
  assign done_o      = seg_end && (direct_q || last_q);
  assign err_o       = mem_req_o && mem_gnt_i && mem_err_i;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign cdar_o = cdar_q;

  always_comb begin
    unique case (state_q)
      ST_FETCH: mem_addr_o = cdar_q + (DW'(fidx_q) << OFFW);
      ST_READ:  mem_addr_o = src_q;
      ST_WRITE: mem_addr_o = dst_q;
      default:  mem_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      cdar_q   <= '0;
      next_q   <= '0;
      buf_q    <= '0;
      fidx_q   <= '0;
      last_q   <= 1'b0;
      direct_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sw_we_i) begin
            if (sw_sel_i == REG_SRC)  src_q  <= sw_wdata_i;
            if (sw_sel_i == REG_DST)  dst_q  <= sw_wdata_i;
            if (sw_sel_i == REG_CNT)  cnt_q  <= sw_wdata_i;
            if (sw_sel_i == REG_CDAR) cdar_q <= sw_wdata_i;
          end
          if (start_i) begin
            direct_q <= direct_i;
            last_q   <= 1'b0;
            fidx_q   <= '0;
            state_q  <= direct_i ? ST_CHECK : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_gnt_i) begin
            if (mem_err_i) begin
              state_q <= ST_IDLE;
            end else begin
              case (int'(fidx_q))
                0:       src_q <= mem_rdata_i;
                1:       dst_q <= mem_rdata_i;
                2: begin
                  next_q <= mem_rdata_i & ~ALIGN;
                  last_q <= mem_rdata_i[0];
                end
                default: cnt_q <= mem_rdata_i;
              endcase
              fidx_q <= fidx_q + 1'b1;
              if (fidx_q == IDXW'(DESC_WORDS - 1)) state_q <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (cnt_q == '0) begin
            if (direct_q || last_q) begin
              state_q <= ST_IDLE;
            end else begin
              cdar_q  <= next_q;
              fidx_q  <= '0;
              state_q <= ST_FETCH;
            end
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_gnt_i) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              buf_q   <= mem_rdata_i;
              state_q <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_gnt_i) begin
            if (mem_err_i) state_q <= ST_IDLE;
            else begin
              src_q   <= src_q + STEP;
              dst_q   <= dst_q + STEP;
              cnt_q   <= (cnt_q > STEP) ? cnt_q - STEP : '0;
              state_q <= ST_CHECK;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o && mem_gnt_i && mem_err_i |=> !busy_o && !mem_req_o); // R7
  AST_ERR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o && mem_gnt_i && mem_err_i |=> $stable(src_q) && $stable(dst_q)); // R7
  AST_CNT_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o && mem_gnt_i && !mem_err_i |=> cnt_q < $past(cnt_q)); // R3
endmodule

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
  import dma_chain_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [DW-1:0]     src_i,
  input  logic [DW-1:0]     dst_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic [DW-1:0]     cdar_i,
  output logic              start_o,
  output logic              direct_o,
  output logic              irq_o
);
  logic [2:0] mode_q;
  logic       err_q, done_q;
  logic       mode_wr, stat_wr;

  assign mode_wr  = reg_we_i && (reg_addr_i == REG_MODE);
  assign stat_wr  = reg_we_i && (reg_addr_i == REG_STAT);
  assign start_o  = mode_wr && reg_wdata_i[MODE_GO] && !mode_q[MODE_GO] && !busy_i;
  assign direct_o = reg_wdata_i[MODE_DIRECT];
  assign irq_o    = err_q || (done_q && mode_q[MODE_EOT_IE]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= reg_wdata_i[2:0];
      // set wins over a same-cycle clear
      if (err_i) err_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_ERR]) err_q <= 1'b0;
      if (done_i) done_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_MODE: reg_rdata_o[2:0] = mode_q;
      REG_STAT: begin
        reg_rdata_o[STAT_BUSY] = busy_i;
        reg_rdata_o[STAT_ERR]  = err_q;
        reg_rdata_o[STAT_DONE] = done_q;
      end
      REG_SRC:  reg_rdata_o = src_i;
      REG_DST:  reg_rdata_o = dst_i;
      REG_CNT:  reg_rdata_o = cnt_i;
      REG_CDAR: reg_rdata_o = cdar_i;
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) start_o |=> busy_i); // R4
  AST_ERR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni) err_i |=> irq_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_i |=> !busy_i); // R6
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni) done_i && mode_q[MODE_EOT_IE] && !mode_wr |=> irq_o); // R6
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_err_i,
  output logic              irq_o
);
  logic          start, direct, busy, done, err;
  logic [DW-1:0] src, dst, cnt, cdar;

  dma_chain_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_i(done), .err_i(err),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .cdar_i(cdar),
    .start_o(start), .direct_o(direct), .irq_o
  );

  dma_chain_engine #(.DW(DW)) u_engine (
    .clk_i, .rst_ni,
    .start_i(start), .direct_i(direct),
    .sw_we_i(reg_we_i), .sw_sel_i(reg_addr_i), .sw_wdata_i(reg_wdata_i),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rdata_i, .mem_err_i,
    .busy_o(busy), .done_o(done), .err_o(err),
    .src_o(src), .dst_o(dst), .cnt_o(cnt), .cdar_o(cdar)
  );
endmodule

// File: tb/dma_chain_channel_test.sv
module dma_chain_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_a[$];
  logic [31:0] exp_d[$];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        stall_en = 1'b0;
  logic        phase = 1'b0;
  int tests = 0, fails = 0, req_cycles = 0, cycles = 0;

  always #5 clk = ~clk;

  dma_chain_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .irq_o(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hC0DE_0000 ^ a;
  endfunction

  // memory model
  always_comb begin
    mem_gnt   = mem_req && (!stall_en || phase);
    mem_rdata = mem[mem_addr[11:2]];
    mem_err   = mem_req && (mem_addr == err_addr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference: every accepted write is compared with the next expected one
  always @(negedge clk) begin
    phase <= ~phase;
    if (mem_req) req_cycles++;
    if (mem_req && mem_we && mem_gnt && !mem_err) begin
      mem[mem_addr[11:2]] = mem_wdata;
      if (exp_a.size() == 0) begin
        tests++; fails++;
        $display("FAIL R3/R5: unexpected write actual %h expected none", mem_addr);
      end else begin
        check("R3/R5 write addr", mem_addr, exp_a.pop_front());
        check("R3/R5 write data", mem_wdata, exp_d.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic launch(input logic direct, input logic ie);
    reg_write(3'd0, {29'd0, ie, direct, 1'b0});
    reg_write(3'd0, {29'd0, ie, direct, 1'b1});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      reg_read(3'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic expect_copy(input logic [31:0] s, input logic [31:0] d, input int words);
    for (int i = 0; i < words; i++) begin
      exp_a.push_back(d + 32'(4 * i));
      exp_d.push_back(mem[(s[11:2]) + 10'(i)]);
    end
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i * 4));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(3'd1, v);
    check("R1 status", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 req", {31'd0, mem_req}, 32'd0);

    // R3/R4/R6 register mode, 3 words, interrupt enabled
    reg_write(3'd2, 32'h100); reg_write(3'd3, 32'h400); reg_write(3'd4, 32'd12);
    expect_copy(32'h100, 32'h400, 3);
    launch(1'b1, 1'b1);
    reg_read(3'd1, v);
    check("R4 busy during copy", {31'd0, v[0]}, 32'd1);
    wait_idle();
    check("R3 all writes seen", 32'(exp_a.size()), 32'd0);
    reg_read(3'd1, v);
    check("R6 done status", v, 32'd4);
    check("R6 irq enabled", {31'd0, irq}, 32'd1);
    reg_read(3'd2, v); check("R3 src advanced", v, 32'h10C);
    reg_read(3'd4, v); check("R3 count zero", v, 32'd0);
    reg_read(3'd1, v); reg_write(3'd1, v);
    check("R8 irq cleared by write-back", {31'd0, irq}, 32'd0);
    reg_read(3'd1, v); check("R8 status cleared", v, 32'd0);

    // R3 rounding, R6 interrupt disabled
    reg_write(3'd2, 32'h200); reg_write(3'd3, 32'h500); reg_write(3'd4, 32'd6);
    expect_copy(32'h200, 32'h500, 2);
    launch(1'b1, 1'b0);
    wait_idle();
    check("R3 rounded writes seen", 32'(exp_a.size()), 32'd0);
    check("R3 word past count untouched", mem[32'h508 >> 2], pat(32'h508));
    check("R6 irq gated off", {31'd0, irq}, 32'd0);
    reg_read(3'd1, v); check("R6 done without irq", v, 32'd4);
    reg_write(3'd1, 32'd4);

    // R2 writing 1 over 1 does not launch
    reg_write(3'd4, 32'd8);
    r0 = req_cycles;
    reg_write(3'd0, 32'h3);
    repeat (5) @(negedge clk);
    reg_read(3'd1, v);
    check("R2 no relaunch busy", v, 32'd0);
    check("R2 no relaunch requests", 32'(req_cycles - r0), 32'd0);
    reg_read(3'd4, v); check("R2 count untouched", v, 32'd8);

    // R5 chain of three with an empty middle descriptor, stalled grants
    mem[32'h600 >> 2] = 32'h100; mem[32'h604 >> 2] = 32'h700;
    mem[32'h608 >> 2] = 32'h620; mem[32'h60C >> 2] = 32'd8;
    mem[32'h620 >> 2] = 32'h140; mem[32'h624 >> 2] = 32'h740;
    mem[32'h628 >> 2] = 32'h642; mem[32'h62C >> 2] = 32'd0;
    mem[32'h640 >> 2] = 32'h180; mem[32'h644 >> 2] = 32'h780;
    mem[32'h648 >> 2] = 32'h661; mem[32'h64C >> 2] = 32'd4;
    expect_copy(32'h100, 32'h700, 2);
    expect_copy(32'h180, 32'h780, 1);
    stall_en = 1'b1;
    reg_write(3'd5, 32'h600);
    launch(1'b0, 1'b1);
    reg_read(3'd1, v);
    check("R4 busy in chain", {31'd0, v[0]}, 32'd1);
    wait_idle();
    stall_en = 1'b0;
    check("R5 chain writes seen", 32'(exp_a.size()), 32'd0);
    check("R5 empty descriptor moved nothing", mem[32'h740 >> 2], pat(32'h740));
    reg_read(3'd5, v); check("R5 last descriptor address", v, 32'h640);
    check("R6 chain irq", {31'd0, irq}, 32'd1);
    reg_write(3'd1, 32'd6);

    // R7 read error on second word, interrupt disabled
    err_addr = 32'h104;
    reg_write(3'd2, 32'h100); reg_write(3'd3, 32'h800); reg_write(3'd4, 32'd16);
    expect_copy(32'h100, 32'h800, 1);
    launch(1'b1, 1'b0);
    wait_idle();
    check("R7 only first write", 32'(exp_a.size()), 32'd0);
    reg_read(3'd1, v); check("R7 error status", v, 32'd2);
    check("R7 irq despite disable", {31'd0, irq}, 32'd1);
    reg_read(3'd2, v); check("R7 src held", v, 32'h104);
    reg_read(3'd3, v); check("R7 dst held", v, 32'h804);
    reg_write(3'd1, 32'd2);
    check("R8 error cleared", {31'd0, irq}, 32'd0);

    // R10 zero count
    err_addr = 32'hFFFF_FFFF;
    reg_write(3'd4, 32'd0);
    r0 = req_cycles;
    launch(1'b1, 1'b1);
    wait_idle();
    check("R10 no memory access", 32'(req_cycles - r0), 32'd0);
    reg_read(3'd1, v); check("R10 done", v, 32'd4);
    check("R10 irq", {31'd0, irq}, 32'd1);
    reg_write(3'd1, 32'd4);

    // R7 error during descriptor fetch
    err_addr = 32'h908;
    reg_write(3'd5, 32'h900);
    r0 = req_cycles;
    launch(1'b0, 1'b0);
    wait_idle();
    reg_read(3'd1, v); check("R7 fetch error status", v, 32'd2);
    reg_read(3'd5, v); check("R7 descriptor address held", v, 32'h900);
    check("R7 fetch stopped at third word", 32'(req_cycles - r0), 32'd3);
    check("R7 no stray writes", 32'(exp_a.size()), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule